// File: doc/BRIEF.md
# 2D Block Load Address Generator

This block fetches a rectangular tile out of a row-major two-dimensional surface held in memory. Software first programs a surface descriptor: the base byte address, the surface height and width in elements, the row pitch in elements, the tile origin as signed row and column offsets, and the tile height and width. It then issues load commands. Each load command picks an element size, how many side-by-side tiles to gather, whether surface bounds are enforced, and one optional reordering (row-pair/quad packing or a column-major transpose). The walker converts each tile element into a byte address, sends an in-order read request for every element that has to come from memory, and puts the returned data together into a 32-bit result stream.

A separate adjust command moves the tile origin by signed deltas and leaves the shape and the pitch unchanged. This lets a kernel step through a large matrix tile by tile. Elements that fall outside the surface, and the filler rows that packing adds below a short tile, are returned as zero and never read. Illegal mode mixes raise an error flag instead of running.

All three data interfaces use valid/ready handshakes. A transfer happens on a rising clock edge where both valid and ready are high. Once valid is raised, the payload holds steady until that transfer. The read request stream stalls as long as `rd_ready` is low, and the result stream stalls as long as `res_ready` is low. Memory responses must come back in request order, and any of them can be held off by `rsp_valid`. Back-pressure on the result port travels back through a small token queue until it stops the address walker. A new command is taken only while the walker is idle.

Top module: `blk2d_load`

## Requirements
- R1: Command `cmd_op` encodes 0 = set descriptor, 1 = adjust origin, 2 = load, 3 = no operation. For a load, element (r,c) of the tile is read at base + ((row_offset + r) * pitch + (column_offset + c)) * bytes. The element size code is 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes. Exactly one read is issued per element that is fetched.
- R2: Results leave in row-major order of the final layout, one element per 32-bit word, zero-extended from its element width, and `res_last` is high only on the final word of a load.
- R3: `cmd_arr_m1` holds the number of side-by-side tiles minus one (0 gives a single tile). N tiles are returned as one tile of the same height and N times the width.
- R4: With bounds checking on (`cmd_bchk`=1), an element whose row lies outside 0..height-1 or whose column lies outside 0..width-1 of the surface is returned as zero and is not read.
- R5: With bounds checking off, every tile element is read at the R1 address, computed with signed coordinates and wrapping modulo 2^32.
- R6: Packing (`cmd_packed`=1, 8- or 16-bit elements) combines 32/width elements of one column from consecutive tile rows into one word. The uppermost row goes in the lowest bits. Words are ordered by row group and then by column. Rows below the tile height are filled with zero and not read.
- R7: Transpose (`cmd_trans`=1, 32-bit elements only) returns the tile in column-major order: all rows of column 0 first, then column 1, and so on.
- R8: A load with packing and transpose together, packing with 32-bit elements, transpose with elements other than 32-bit, size code 3, or a zero tile height or width sets `err`. Such a load issues no read and no result. The next legal load clears `err`.
- R9: An adjust command adds `cmd_row` and `cmd_col` as signed deltas to the tile origin. The surface, pitch and tile shape stay the same.
- R10: `rd_valid` and `rd_addr` stay unchanged while a request waits for `rd_ready`, and `cmd_ready` is low while reads are being issued.
- R11: `res_valid`, `res_data` and `res_last` stay unchanged while a result waits for `res_ready`.
- R12: After reset, `cmd_ready` is high and `rd_valid`, `res_valid` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command valid |
| cmd_ready | output | 1 | Command accepted when high (walker idle) |
| cmd_op | input | 2 | 0 set, 1 adjust, 2 load, 3 no-op |
| cmd_base | input | AW | Surface base byte address (set) |
| cmd_surf_h | input | CW | Surface height in elements (set) |
| cmd_surf_w | input | CW | Surface width in elements (set) |
| cmd_pitch | input | CW | Row pitch in elements (set) |
| cmd_row | input | CW | Signed row origin (set) or delta (adjust) |
| cmd_col | input | CW | Signed column origin (set) or delta (adjust) |
| cmd_blk_h | input | DIMW | Tile height (set) |
| cmd_blk_w | input | DIMW | Tile width (set) |
| cmd_arr_m1 | input | ARRW | Side-by-side tile count minus one (load) |
| cmd_esz | input | 2 | Element size code (load) |
| cmd_bchk | input | 1 | Bounds checking enable (load) |
| cmd_packed | input | 1 | Row packing enable (load) |
| cmd_trans | input | 1 | Transpose enable (load) |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | AW | Read byte address |
| rsp_valid | input | 1 | Read data valid (in request order) |
| rsp_ready | output | 1 | Read data accepted |
| rsp_data | input | 32 | Read data, element in the low bits |
| res_valid | output | 1 | Result word valid |
| res_ready | input | 1 | Result word accepted |
| res_data | output | 32 | Result word |
| res_last | output | 1 | Final word of the load |
| err | output | 1 | Last load command was illegal |

## Verification
The tile walk runs with each element size on an interior tile, which separates address scaling from ordering. A multi-tile load shows whether the combined width is walked as one row. A tile that hangs over the bottom and left edges is loaded twice, once with bounds checking and once without, which separates zero-filling and read suppression from signed, wrapping address arithmetic. Packing is tried at 16 bits and at 8 bits with a height that is not a multiple of four, to expose wrong lane placement and filler rows. A multi-tile transpose checks the column-major order. Random stalls on all three handshakes run the whole time, so that lost or repeated elements show up, and illegal mode mixes followed by an origin adjust check the error flag and that the adjust is relative.

// File: rtl/blk2d_pkg.sv
package blk2d_pkg;

  typedef enum logic [1:0] {
    OP_SET  = 2'd0,
    OP_ADJ  = 2'd1,
    OP_LOAD = 2'd2,
    OP_NOP  = 2'd3
  } blk_op_e;

  typedef enum logic [1:0] {
    ES_8   = 2'd0,
    ES_16  = 2'd1,
    ES_32  = 2'd2,
    ES_BAD = 2'd3
  } elem_sz_e;

  // one token per walked element, consumed in order by the assembler
  typedef struct packed {
    logic       zero;  // element is filled with zero, no read was issued
    logic [1:0] kidx;  // lane inside the packed word
    logic [1:0] esz;   // element size code
    logic       wend;  // last lane of the word
    logic       last;  // last element of the load
  } blk_tok_t;

endpackage

// File: rtl/blk2d_fifo.sv
module blk2d_fifo #(
  parameter int W     = 7,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int PW = $clog2(DEPTH);

  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [PW:0]   cnt;

  assign full  = (cnt == (PW+1)'(DEPTH));
  assign empty = (cnt == '0);
  assign dout  = store[rptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (push && !full) begin
        store[wptr] <= din;
        wptr        <= wptr + PW'(1);
      end
      if (pop && !empty) rptr <= rptr + PW'(1);
      case ({push && !full, pop && !empty})
        2'b10:   cnt <= cnt + (PW+1)'(1);
        2'b01:   cnt <= cnt - (PW+1)'(1);
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/blk2d_walker.sv
module blk2d_walker
  import blk2d_pkg::*;
#(
  parameter int AW   = 32,
  parameter int CW   = 16,
  parameter int DIMW = 6,
  parameter int ARRW = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [AW-1:0]        base,
  input  logic [CW-1:0]        surf_h,
  input  logic [CW-1:0]        surf_w,
  input  logic [CW-1:0]        pitch,
  input  logic signed [CW-1:0] row0,
  input  logic signed [CW-1:0] col0,
  input  logic [DIMW-1:0]      blk_h,
  input  logic [DIMW-1:0]      blk_w,
  input  logic [ARRW-1:0]      arr_m1,
  input  logic [1:0]           esz,
  input  logic                 bchk,
  input  logic                 packed_en,
  input  logic                 trans_en,
  output logic                 busy,
  output logic                 rd_valid,
  input  logic                 rd_ready,
  output logic [AW-1:0]        rd_addr,
  output logic                 tok_push,
  output blk_tok_t             tok,
  input  logic                 tok_full
);
  localparam int TW = DIMW + ARRW;    // combined tile width
  localparam int RW = TW + 2;         // local row incl. packing filler
  localparam int XW = CW + TW + 2;    // absolute signed coordinate
  localparam int LW = XW + CW + 1;    // linear element index

  logic [AW-1:0]        l_base;
  logic [CW-1:0]        l_sh, l_sw, l_pitch;
  logic signed [CW-1:0] l_row0, l_col0;
  logic [DIMW-1:0]      l_bh;
  logic [TW-1:0]        l_tw;
  logic [1:0]           l_esz, l_ksh;
  logic                 l_bchk, l_tr;
  logic [TW-1:0]        cnt_a, cnt_b;
  logic [1:0]           cnt_k;

  logic [1:0]           kmax;
  logic [TW-1:0]        ngrp, a_lim, b_lim;
  logic [RW-1:0]        loc_r;
  logic [TW-1:0]        loc_c;
  logic signed [XW-1:0] abs_r, abs_c;
  logic signed [LW-1:0] lin;
  logic                 outside, pad_row, zero, k_end, b_end, a_end, step;

  assign kmax  = 2'((3'd1 << l_ksh) - 3'd1);
  assign ngrp  = TW'((TW'(l_bh) + TW'(kmax)) >> l_ksh);
  assign a_lim = l_tr ? l_tw : ngrp;
  assign b_lim = l_tr ? TW'(l_bh) : l_tw;

  // map walk counters to tile coordinates
  assign loc_r = l_tr ? RW'(cnt_b) : ((RW'(cnt_a) << l_ksh) + RW'(cnt_k));
  assign loc_c = l_tr ? cnt_a : cnt_b;
  assign abs_r = XW'(l_row0) + $signed(XW'(loc_r));
  assign abs_c = XW'(l_col0) + $signed(XW'(loc_c));

  assign outside = (abs_r < 0) || (abs_r >= $signed(XW'(l_sh))) ||
                   (abs_c < 0) || (abs_c >= $signed(XW'(l_sw)));
  assign pad_row = (loc_r >= RW'(l_bh));
  assign zero    = pad_row || (l_bchk && outside);

  assign lin     = LW'(abs_r) * $signed(LW'(l_pitch)) + LW'(abs_c);
  assign rd_addr = l_base + AW'(lin <<< l_esz);

  assign k_end = (cnt_k == kmax);
  assign b_end = (cnt_b == b_lim - TW'(1));
  assign a_end = (cnt_a == a_lim - TW'(1));

  assign rd_valid = busy && !zero && !tok_full;
  assign step     = busy && !tok_full && (zero || rd_ready);
  assign tok_push = step;

  always_comb begin
    tok.zero = zero;
    tok.kidx = cnt_k;
    tok.esz  = l_esz;
    tok.wend = k_end;
    tok.last = k_end && b_end && a_end;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      l_base  <= '0;
      l_sh    <= '0;
      l_sw    <= '0;
      l_pitch <= '0;
      l_row0  <= '0;
      l_col0  <= '0;
      l_bh    <= '0;
      l_tw    <= '0;
      l_esz   <= '0;
      l_ksh   <= '0;
      l_bchk  <= 1'b0;
      l_tr    <= 1'b0;
      cnt_a   <= '0;
      cnt_b   <= '0;
      cnt_k   <= '0;
    end else if (start && !busy) begin
      busy    <= 1'b1;
      l_base  <= base;
      l_sh    <= surf_h;
      l_sw    <= surf_w;
      l_pitch <= pitch;
      l_row0  <= row0;
      l_col0  <= col0;
      l_bh    <= blk_h;
      l_tw    <= TW'(blk_w) * (TW'(arr_m1) + TW'(1));
      l_esz   <= esz;
      l_ksh   <= !packed_en ? 2'd0 : (esz == ES_8) ? 2'd2 : 2'd1;
      l_bchk  <= bchk;
      l_tr    <= trans_en;
      cnt_a   <= '0;
      cnt_b   <= '0;
      cnt_k   <= '0;
    end else if (step) begin
      if (!k_end) begin
        cnt_k <= cnt_k + 2'd1;
      end else begin
        cnt_k <= '0;
        if (!b_end) begin
          cnt_b <= cnt_b + TW'(1);
        end else begin
          cnt_b <= '0;
          if (!a_end) cnt_a <= cnt_a + TW'(1);
          else        busy  <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/blk2d_pack.sv
module blk2d_pack
  import blk2d_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tok_valid,
  input  blk_tok_t    tok,
  output logic        tok_pop,
  input  logic        rsp_valid,
  output logic        rsp_ready,
  input  logic [31:0] rsp_data,
  output logic        res_valid,
  input  logic        res_ready,
  output logic [31:0] res_data,
  output logic        res_last
);
  logic [31:0] acc, elem, merged, mask;
  logic [4:0]  shamt;
  logic        can_take;

  assign can_take = !res_valid || res_ready;

  always_comb begin
    case (tok.esz)
      ES_8:    mask = 32'h0000_00ff;
      ES_16:   mask = 32'h0000_ffff;
      default: mask = 32'hffff_ffff;
    endcase
  end

  assign elem      = tok.zero ? 32'h0 : (rsp_data & mask);
  assign shamt     = 5'(tok.kidx) << (3'd3 + 3'(tok.esz));
  assign merged    = ((tok.kidx == 2'd0) ? 32'h0 : acc) | (elem << shamt);
  assign rsp_ready = tok_valid && !tok.zero && can_take;
  assign tok_pop   = tok_valid && can_take && (tok.zero || rsp_valid);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc       <= '0;
      res_valid <= 1'b0;
      res_data  <= '0;
      res_last  <= 1'b0;
    end else begin
      if (res_valid && res_ready) res_valid <= 1'b0;
      if (tok_pop) begin
        if (tok.wend) begin
          res_valid <= 1'b1;
          res_data  <= merged;
          res_last  <= tok.last;
        end else begin
          acc <= merged;
        end
      end
    end
  end
endmodule

// File: rtl/blk2d_load.sv
module blk2d_load
  import blk2d_pkg::*;
#(
  parameter int AW     = 32,
  parameter int CW     = 16,
  parameter int DIMW   = 6,
  parameter int ARRW   = 2,
  parameter int QDEPTH = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [1:0]      cmd_op,
  input  logic [AW-1:0]   cmd_base,
  input  logic [CW-1:0]   cmd_surf_h,
  input  logic [CW-1:0]   cmd_surf_w,
  input  logic [CW-1:0]   cmd_pitch,
  input  logic [CW-1:0]   cmd_row,
  input  logic [CW-1:0]   cmd_col,
  input  logic [DIMW-1:0] cmd_blk_h,
  input  logic [DIMW-1:0] cmd_blk_w,
  input  logic [ARRW-1:0] cmd_arr_m1,
  input  logic [1:0]      cmd_esz,
  input  logic            cmd_bchk,
  input  logic            cmd_packed,
  input  logic            cmd_trans,
  output logic            rd_valid,
  input  logic            rd_ready,
  output logic [AW-1:0]   rd_addr,
  input  logic            rsp_valid,
  output logic            rsp_ready,
  input  logic [31:0]     rsp_data,
  output logic            res_valid,
  input  logic            res_ready,
  output logic [31:0]     res_data,
  output logic            res_last,
  output logic            err
);
  localparam int TOKW = $bits(blk_tok_t);

  logic [AW-1:0]        d_base;
  logic [CW-1:0]        d_sh, d_sw, d_pitch;
  logic signed [CW-1:0] d_row, d_col;
  logic [DIMW-1:0]      d_bh, d_bw;

  logic     busy, accept, is_load, bad, start;
  logic     tok_push, tok_full, tok_empty, tok_pop;
  blk_tok_t tok_in, tok_out;
  blk_op_e  op;

  assign op        = blk_op_e'(cmd_op);
  assign cmd_ready = !busy;
  assign accept    = cmd_valid && cmd_ready;
  assign is_load   = accept && (op == OP_LOAD);

  assign bad = (d_bh == '0) || (d_bw == '0) || (cmd_esz == ES_BAD) ||
               (cmd_packed && cmd_trans) ||
               (cmd_packed && cmd_esz == ES_32) ||
               (cmd_trans && cmd_esz != ES_32);
  assign start = is_load && !bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_base  <= '0;
      d_sh    <= '0;
      d_sw    <= '0;
      d_pitch <= '0;
      d_row   <= '0;
      d_col   <= '0;
      d_bh    <= '0;
      d_bw    <= '0;
      err     <= 1'b0;
    end else if (accept) begin
      case (op)
        OP_SET: begin
          d_base  <= cmd_base;
          d_sh    <= cmd_surf_h;
          d_sw    <= cmd_surf_w;
          d_pitch <= cmd_pitch;
          d_row   <= $signed(cmd_row);
          d_col   <= $signed(cmd_col);
          d_bh    <= cmd_blk_h;
          d_bw    <= cmd_blk_w;
        end
        OP_ADJ: begin
          d_row <= d_row + $signed(cmd_row);
          d_col <= d_col + $signed(cmd_col);
        end
        OP_LOAD: err <= bad;
        default: ;
      endcase
    end
  end

  blk2d_walker #(
    .AW(AW), .CW(CW), .DIMW(DIMW), .ARRW(ARRW)
  ) walker_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .base(d_base), .surf_h(d_sh), .surf_w(d_sw), .pitch(d_pitch),
    .row0(d_row), .col0(d_col), .blk_h(d_bh), .blk_w(d_bw),
    .arr_m1(cmd_arr_m1), .esz(cmd_esz), .bchk(cmd_bchk),
    .packed_en(cmd_packed), .trans_en(cmd_trans),
    .busy(busy), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
    .tok_push(tok_push), .tok(tok_in), .tok_full(tok_full)
  );

  blk2d_fifo #(.W(TOKW), .DEPTH(QDEPTH)) tokq_i (
    .clk(clk), .rst_n(rst_n),
    .push(tok_push), .din(tok_in),
    .pop(tok_pop), .dout(tok_out),
    .full(tok_full), .empty(tok_empty)
  );

  blk2d_pack pack_i (
    .clk(clk), .rst_n(rst_n),
    .tok_valid(!tok_empty), .tok(tok_out), .tok_pop(tok_pop),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .res_last(res_last)
  );
endmodule

// File: rtl/blk2d_load_chk.sv
module blk2d_load_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic          rd_valid,
  input logic          rd_ready,
  input logic [AW-1:0] rd_addr,
  input logic          res_valid,
  input logic          res_ready,
  input logic [31:0]   res_data,
  input logic          res_last,
  input logic          err
);
  assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr));

  assert_cmd_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !cmd_ready);

  assert_res_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_data) && $stable(res_last));

  assert_err_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !rd_valid);

  assert_reset_R12: assert property (@(posedge clk)
    !rst_n |=> !rd_valid && !res_valid && !err && cmd_ready);

  logic unused_cmd_valid;
  assign unused_cmd_valid = cmd_valid;
endmodule

bind blk2d_load blk2d_load_chk #(.AW(AW)) chk_i (.*);

// File: tb/blk2d_load_test.sv
module blk2d_load_test;
  localparam int AW = 32, CW = 16, DIMW = 6, ARRW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready;
  logic [1:0] cmd_op = '0;
  logic [AW-1:0] cmd_base = '0;
  logic [CW-1:0] cmd_surf_h = '0, cmd_surf_w = '0, cmd_pitch = '0, cmd_row = '0, cmd_col = '0;
  logic [DIMW-1:0] cmd_blk_h = '0, cmd_blk_w = '0;
  logic [ARRW-1:0] cmd_arr_m1 = '0;
  logic [1:0] cmd_esz = '0;
  logic cmd_bchk = 1'b0, cmd_packed = 1'b0, cmd_trans = 1'b0;
  logic rd_valid, rd_ready = 1'b0;
  logic [AW-1:0] rd_addr;
  logic rsp_valid = 1'b0, rsp_ready;
  logic [31:0] rsp_data = '0;
  logic res_valid, res_ready = 1'b0;
  logic [31:0] res_data;
  logic res_last, err;

  always #5 clk = ~clk;

  blk2d_load uut (.*);

  int n_chk = 0, n_err = 0;
  bit done = 0;
  string cur_req = "R1";
  logic [31:0] exp_rd[$];
  logic [32:0] exp_res[$];
  logic [31:0] rsp_q[$];

  int bd_base, bd_sh, bd_sw, bd_pitch, bd_ro, bd_co, bd_bh, bd_bw;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[15:0] ^ 16'hc3a5, a[7:0] + 8'h3c, a[15:8] ^ 8'h96};
  endfunction

  // expected reads and results, derived from the requirements
  task automatic model_load(input int esz, input int arr_m1, input bit bchk,
                            input bit pk, input bit tr);
    int ew, kk, tw, ng, alim, blim;
    logic [31:0] word, mask, v;
    ew   = 8 << esz;
    kk   = pk ? 32 / ew : 1;
    tw   = bd_bw * (arr_m1 + 1);
    ng   = (bd_bh + kk - 1) / kk;
    alim = tr ? tw : ng;
    blim = tr ? bd_bh : tw;
    mask = (esz == 2) ? 32'hffff_ffff : ((32'h1 << ew) - 1);
    word = '0;
    for (int a = 0; a < alim; a++)
      for (int b = 0; b < blim; b++)
        for (int k = 0; k < kk; k++) begin
          int r, c;
          longint ar, ac, lin;
          bit zero;
          logic [31:0] addr;
          r  = tr ? b : a * kk + k;
          c  = tr ? a : b;
          ar = bd_ro + r;
          ac = bd_co + c;
          zero = (r >= bd_bh) ||
                 (bchk && (ar < 0 || ar >= bd_sh || ac < 0 || ac >= bd_sw));
          lin  = (ar * bd_pitch + ac) << esz;
          addr = 32'(bd_base) + 32'(lin);
          if (!zero) begin
            exp_rd.push_back(addr);
            v = mem_word(addr) & mask;
          end else v = '0;
          if (k == 0) word = '0;
          word = word | (v << (k * ew));
          if (k == kk - 1)
            exp_res.push_back({(a == alim-1 && b == blim-1), word});
        end
  endtask

  task automatic issue();
    bit ok;
    cmd_valid = 1'b1;
    do begin
      #1 ok = cmd_ready;
      if (!ok) @(negedge clk);
    end while (!ok);
    @(posedge clk);
    #1 cmd_valid = 1'b0;
  endtask

  task automatic set_desc(input int base, input int sh, input int sw, input int pitch,
                          input int ro, input int co, input int bh, input int bw);
    bd_base = base; bd_sh = sh; bd_sw = sw; bd_pitch = pitch;
    bd_ro = ro; bd_co = co; bd_bh = bh; bd_bw = bw;
    @(negedge clk);
    cmd_op = 2'd0; cmd_base = 32'(base); cmd_surf_h = 16'(sh); cmd_surf_w = 16'(sw);
    cmd_pitch = 16'(pitch); cmd_row = 16'(ro); cmd_col = 16'(co);
    cmd_blk_h = 6'(bh); cmd_blk_w = 6'(bw);
    issue();
  endtask

  task automatic adjust(input int dr, input int dc);
    bd_ro += dr; bd_co += dc;
    @(negedge clk);
    cmd_op = 2'd1; cmd_row = 16'(dr); cmd_col = 16'(dc);
    issue();
  endtask

  task automatic wait_drain();
    while (exp_res.size() > 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(exp_rd.size() == 0, cur_req, "reads missing", 64'(exp_rd.size()), 0);
  endtask

  task automatic do_load(input string req, input int esz, input int arr_m1,
                         input bit bchk, input bit pk, input bit tr);
    cur_req = req;
    model_load(esz, arr_m1, bchk, pk, tr);
    @(negedge clk);
    cmd_op = 2'd2; cmd_esz = 2'(esz); cmd_arr_m1 = 2'(arr_m1);
    cmd_bchk = bchk; cmd_packed = pk; cmd_trans = tr;
    issue();
    chk(err == 1'b0, "R8", "err after legal load", 64'(err), 0);
    wait_drain();
  endtask

  task automatic bad_load(input int esz, input bit pk, input bit tr);
    cur_req = "R8";
    @(negedge clk);
    cmd_op = 2'd2; cmd_esz = 2'(esz); cmd_arr_m1 = '0;
    cmd_bchk = 1'b1; cmd_packed = pk; cmd_trans = tr;
    issue();
    repeat (6) @(negedge clk);
    chk(err == 1'b1, "R8", "err after illegal load", 64'(err), 1);
    chk(cmd_ready == 1'b1, "R8", "walker idle after illegal load", 64'(cmd_ready), 1);
  endtask

  // monitor: drives sink/memory handshakes, compares against the scoreboard
  bit prev_rd_stall = 0, prev_res_stall = 0;
  logic [31:0] prev_addr, prev_res;
  logic prev_last;

  initial begin
    forever begin
      @(negedge clk);
      rd_ready  = ($urandom % 4) != 0;
      res_ready = ($urandom % 3) != 0;
      if (rsp_q.size() > 0 && ($urandom % 4) != 0) begin
        rsp_valid = 1'b1;
        rsp_data  = rsp_q[0];
      end else begin
        rsp_valid = 1'b0;
        rsp_data  = $urandom;
      end
      #1;
      if (rst_n) begin
        if (prev_rd_stall)
          chk(rd_valid && rd_addr == prev_addr, "R10", "stalled request changed",
              {31'(0), rd_valid, rd_addr}, {32'h1, prev_addr});
        if (prev_res_stall)
          chk(res_valid && res_data == prev_res && res_last == prev_last, "R11",
              "stalled result changed", {31'(0), res_last, res_data}, {31'(0), prev_last, prev_res});
        if (rd_valid)
          chk(!cmd_ready, "R10", "cmd_ready while reading", 64'(cmd_ready), 0);
        if (rd_valid && rd_ready) begin
          if (exp_rd.size() == 0)
            chk(1'b0, cur_req, "unexpected read", 64'(rd_addr), 0);
          else begin
            logic [31:0] e;
            e = exp_rd.pop_front();
            chk(rd_addr == e, cur_req, "read address", 64'(rd_addr), 64'(e));
          end
          rsp_q.push_back(mem_word(rd_addr));
        end
        if (rsp_valid && rsp_ready) void'(rsp_q.pop_front());
        if (res_valid && res_ready) begin
          if (exp_res.size() == 0)
            chk(1'b0, cur_req, "unexpected result", {31'(0), res_last, res_data}, 0);
          else begin
            logic [32:0] e;
            e = exp_res.pop_front();
            chk({res_last, res_data} == e, cur_req, "result word",
                {31'(0), res_last, res_data}, 64'(e));
          end
        end
        prev_rd_stall  = rd_valid && !rd_ready;
        prev_addr      = rd_addr;
        prev_res_stall = res_valid && !res_ready;
        prev_res       = res_data;
        prev_last      = res_last;
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired during %s", cur_req);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(cmd_ready == 1'b1, "R12", "cmd_ready in reset", 64'(cmd_ready), 1);
    chk(rd_valid == 1'b0 && res_valid == 1'b0, "R12", "valids in reset",
        {62'(0), rd_valid, res_valid}, 0);
    chk(err == 1'b0, "R12", "err in reset", 64'(err), 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1/R2: interior tile, each element size
    set_desc(32'h1000, 20, 40, 48, 2, 3, 4, 5);
    do_load("R1", 1, 0, 1, 0, 0);
    do_load("R2", 0, 0, 1, 0, 0);
    do_load("R2", 2, 0, 1, 0, 0);
    // R3: three side-by-side tiles
    do_load("R3", 1, 2, 1, 0, 0);
    // R4/R5: tile hanging over bottom and left edges
    set_desc(32'h2000, 20, 40, 48, 18, -2, 4, 6);
    do_load("R4", 2, 0, 1, 0, 0);
    do_load("R5", 2, 0, 0, 0, 0);
    // R6: packing, 16-bit and 8-bit with filler rows
    set_desc(32'h3000, 20, 40, 48, 0, 0, 4, 3);
    do_load("R6", 1, 0, 1, 1, 0);
    set_desc(32'h3000, 20, 40, 48, 1, 2, 6, 2);
    do_load("R6", 0, 0, 1, 1, 0);
    // R7: transpose over two tiles
    set_desc(32'h4000, 20, 40, 48, 5, 7, 3, 4);
    do_load("R7", 2, 1, 1, 0, 1);
    // R8: illegal mixes, then recovery
    bad_load(1, 1, 1);
    bad_load(2, 1, 0);
    bad_load(1, 0, 1);
    bad_load(3, 0, 0);
    do_load("R8", 1, 0, 1, 0, 0);
    // R9: relative origin adjust
    set_desc(32'h1000, 20, 40, 48, 2, 3, 4, 5);
    adjust(1, -2);
    do_load("R9", 1, 0, 1, 0, 0);
    adjust(16, 38);
    do_load("R9", 0, 0, 1, 0, 0);
    finish_run();
  end
endmodule